// File: doc/BRIEF.md
# Frame Dump Serial Streamer

Once recording has been frozen, this block copies a run of stored video frames out of the frame memory and sends them over an asynchronous serial link to a long-term storage module. A single `go` pulse starts a dump. The pulse carries three values: the index of the first stored frame, the number of frames to send, and a 3-bit code that picks the line rate. The block then walks the frames in order, wrapping at the end of the circular store. Before each frame it sends an 8-byte header. It then reads the frame's 16-bit pixel words one by one through a read port with one cycle of latency, and sends each word as two bytes.

The receiver throttles the link with a clear-to-send input. A byte that has started always finishes, but a new byte waits until clear-to-send is high. The block holds its request-to-send output and its busy flag high for the whole dump. It gives a one-cycle done pulse just after the last stop bit.

Top module: `frameDumpStreamer`

## Requirements
- R1: After reset `txd` is high (mark), and `rts`, `busy`, `donePulse` and `memRdEn` are low.
- R2: Each byte is sent as one low start bit, then eight data bits with the least significant bit first, then one high stop bit. Every bit lasts CLK_HZ / rate clock cycles, with the quotient rounded down.
- R3: The rate codes 0 through 7 select 1200, 2400, 9600, 28800, 38400, 57600, 115200 and 230400 bit/s. The code is taken only with an accepted `go`. A change of `rateSel` during a dump has no effect on that dump.
- R4: Before each frame's pixels the block sends an 8-byte header in this order: 0xA5, the low 8 bits of the stored frame index, the frame width as 16 bits with the high byte first, the frame height in the same form, and two 0x00 bytes.
- R5: A frame's pixel words are read at addresses frameIndex*WORDS+0 up to frameIndex*WORDS+WORDS-1, in ascending order, where WORDS = FRAME_W*FRAME_H. Each word is sent high byte first and then low byte. A dump of N frames makes exactly N*WORDS reads.
- R6: A dump sends `frameCount` frames, starting at `startFrame`. The frame index that follows NUM_FRAMES-1 is 0.
- R7: A new start bit can begin only if `cts` was high in the clock cycle before the one in which `txd` falls. A byte that is in progress completes unchanged even when `cts` drops.
- R8: `busy` and `rts` are high from the cycle after an accepted `go` until the done pulse, inclusive. `txd` stays high whenever `busy` is low.
- R9: `donePulse` is high for exactly one cycle, 10*divisor+1 cycles after the final start bit begins, which is one cycle after that byte's stop bit ends. `busy` is low in the cycle that follows.
- R10: A `go` that arrives during a dump is ignored. The byte stream and the read count of the running dump do not change.
- R11: A `go` with `frameCount` = 0 gives one done pulse, sends no byte and makes no memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start a dump (taken only while idle) |
| startFrame | input | FRM_W | Index of the first frame to send |
| frameCount | input | CNT_W | Number of frames to send |
| rateSel | input | 3 | Line rate code |
| cts | input | 1 | Clear to send, active high |
| memAddr | output | ADDR_W | Frame memory read address |
| memRdEn | output | 1 | Read strobe; data is valid in the next cycle |
| memRdData | input | 16 | Read data |
| txd | output | 1 | Serial output |
| rts | output | 1 | Request to send, active high |
| busy | output | 1 | Dump in progress |
| donePulse | output | 1 | One-cycle pulse at the end of a dump |

## Verification
Two events can fall in the same cycle. In one, clear-to-send drops in the very cycle the controller wants to start the next byte. In the other, a fresh `go` together with a new rate code lands in the middle of a dump. Random cts toggling on every cycle makes the first collision happen many times per run. Each start bit is judged against the cts value of the cycle before it, and the whole stream is decoded against a model built in the bench. The second collision is forced directly, and the decoded stream, read count and bit timing must be those of the original dump.

// File: rtl/fdsPkg.sv
package fdsPkg;

  typedef struct packed {
    logic       startRun;
    logic       sendHdr;
    logic       sendHi;
    logic       sendLo;
    logic       memRd;
    logic       advWord;
    logic       advFrame;
    logic [2:0] hdrIdx;
  } fdsStrobes_t;

  localparam logic [7:0] HDR_SYNC = 8'hA5;

  // clock cycles per bit for each rate code
  function automatic int unsigned baudDivisor(int unsigned clkHz, logic [2:0] sel);
    case (sel)
      3'd0:    return clkHz / 1200;
      3'd1:    return clkHz / 2400;
      3'd2:    return clkHz / 9600;
      3'd3:    return clkHz / 28800;
      3'd4:    return clkHz / 38400;
      3'd5:    return clkHz / 57600;
      3'd6:    return clkHz / 115200;
      default: return clkHz / 230400;
    endcase
  endfunction

endpackage

// File: rtl/fdsControl.sv
module fdsControl
  import fdsPkg::*;
#(
  parameter int NUM_FRAMES = 27,
  localparam int CNT_W = $clog2(NUM_FRAMES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             go,
  input  logic [CNT_W-1:0] frameCount,
  input  logic             cts,
  input  logic             txIdle,
  input  logic             byteDone,
  input  logic             lastWord,
  output fdsStrobes_t      stb,
  output logic             busy,
  output logic             donePulse
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_FETCH, ST_WAITD, ST_SENDHI, ST_SENDLO, ST_DRAIN, ST_DONE
  } ctrlState_t;

  ctrlState_t       state, stateNext;
  logic [2:0]       hdrCnt, hdrCntNext;
  logic [CNT_W-1:0] framesLeft, framesLeftNext;
  logic             canSend;

  assign canSend = txIdle && cts;

  always_comb begin
    stb            = '0;
    stateNext      = state;
    hdrCntNext     = hdrCnt;
    framesLeftNext = framesLeft;
    case (state)
      ST_IDLE: if (go) begin
        stb.startRun   = 1'b1;
        framesLeftNext = frameCount;
        hdrCntNext     = '0;
        stateNext      = (frameCount == '0) ? ST_DONE : ST_HDR;
      end
      ST_HDR: if (canSend) begin
        stb.sendHdr = 1'b1;
        stb.hdrIdx  = hdrCnt;
        hdrCntNext  = hdrCnt + 3'd1;
        if (hdrCnt == 3'd7) stateNext = ST_FETCH;
      end
      ST_FETCH: begin
        stb.memRd = 1'b1;
        stateNext = ST_WAITD;
      end
      ST_WAITD: stateNext = ST_SENDHI;
      ST_SENDHI: if (canSend) begin
        stb.sendHi = 1'b1;
        stateNext  = ST_SENDLO;
      end
      ST_SENDLO: if (canSend) begin
        stb.sendLo = 1'b1;
        if (!lastWord) begin
          stb.advWord = 1'b1;
          stateNext   = ST_FETCH;
        end else if (framesLeft == CNT_W'(1)) begin
          stateNext = ST_DRAIN;
        end else begin
          stb.advFrame   = 1'b1;
          framesLeftNext = framesLeft - CNT_W'(1);
          hdrCntNext     = '0;
          stateNext      = ST_HDR;
        end
      end
      ST_DRAIN: if (byteDone) stateNext = ST_DONE;
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      hdrCnt     <= '0;
      framesLeft <= '0;
    end else begin
      state      <= stateNext;
      hdrCnt     <= hdrCntNext;
      framesLeft <= framesLeftNext;
    end
  end

  assign busy      = (state != ST_IDLE);
  assign donePulse = (state == ST_DONE);

endmodule

// File: rtl/fdsDatapath.sv
module fdsDatapath
  import fdsPkg::*;
#(
  parameter int CLK_HZ     = 2_000_000,
  parameter int NUM_FRAMES = 27,
  parameter int FRAME_W    = 4,
  parameter int FRAME_H    = 2,
  localparam int WORDS  = FRAME_W * FRAME_H,
  localparam int FRM_W  = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int ADDR_W = $clog2(NUM_FRAMES * WORDS),
  localparam int DIV_W  = $clog2(CLK_HZ / 1200 + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fdsStrobes_t       stb,
  input  logic [FRM_W-1:0]  startFrame,
  input  logic [2:0]        rateSel,
  input  logic [15:0]       memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              txd,
  output logic              txIdle,
  output logic              byteDone,
  output logic              lastWord
);

  localparam logic [15:0] WIDTH16  = 16'(FRAME_W);
  localparam logic [15:0] HEIGHT16 = 16'(FRAME_H);

  logic [DIV_W-1:0]  divReg;
  logic [FRM_W-1:0]  frameIdx;
  logic [WIDX_W-1:0] wordIdx;
  logic [15:0]       wordReg;
  logic              rdPending;

  logic              active;
  logic [9:0]        shiftReg;
  logic [3:0]        bitCnt;
  logic [DIV_W-1:0]  baudCnt;

  logic [7:0]        hdrByte, txByte;
  logic              loadByte;

  // addressing and word capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divReg    <= '0;
      frameIdx  <= '0;
      wordIdx   <= '0;
      wordReg   <= '0;
      rdPending <= 1'b0;
    end else begin
      rdPending <= stb.memRd;
      if (rdPending) wordReg <= memRdData;
      if (stb.startRun) begin
        divReg   <= DIV_W'(baudDivisor(CLK_HZ, rateSel));
        frameIdx <= startFrame;
        wordIdx  <= '0;
      end else if (stb.advFrame) begin
        frameIdx <= (frameIdx == FRM_W'(NUM_FRAMES - 1)) ? '0 : frameIdx + FRM_W'(1);
        wordIdx  <= '0;
      end else if (stb.advWord) begin
        wordIdx <= wordIdx + WIDX_W'(1);
      end
    end
  end

  assign memAddr  = ADDR_W'(frameIdx) * ADDR_W'(WORDS) + ADDR_W'(wordIdx);
  assign lastWord = (wordIdx == WIDX_W'(WORDS - 1));

  // byte source selection
  always_comb begin
    case (stb.hdrIdx)
      3'd0:    hdrByte = HDR_SYNC;
      3'd1:    hdrByte = 8'(frameIdx);
      3'd2:    hdrByte = WIDTH16[15:8];
      3'd3:    hdrByte = WIDTH16[7:0];
      3'd4:    hdrByte = HEIGHT16[15:8];
      3'd5:    hdrByte = HEIGHT16[7:0];
      default: hdrByte = 8'h00;
    endcase
    if (stb.sendHdr)     txByte = hdrByte;
    else if (stb.sendHi) txByte = wordReg[15:8];
    else                 txByte = wordReg[7:0];
  end

  assign loadByte = stb.sendHdr | stb.sendHi | stb.sendLo;

  // serial transmitter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      shiftReg <= '1;
      bitCnt   <= '0;
      baudCnt  <= '0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (loadByte && !active) begin
        active   <= 1'b1;
        shiftReg <= {1'b1, txByte, 1'b0};
        bitCnt   <= 4'd10;
        baudCnt  <= divReg - DIV_W'(1);
      end else if (active) begin
        if (baudCnt == '0) begin
          if (bitCnt == 4'd1) begin
            active   <= 1'b0;
            byteDone <= 1'b1;
          end else begin
            shiftReg <= {1'b1, shiftReg[9:1]};
            bitCnt   <= bitCnt - 4'd1;
            baudCnt  <= divReg - DIV_W'(1);
          end
        end else begin
          baudCnt <= baudCnt - DIV_W'(1);
        end
      end
    end
  end

  assign txd    = active ? shiftReg[0] : 1'b1;
  assign txIdle = !active;

endmodule

// File: rtl/frameDumpStreamer.sv
module frameDumpStreamer
  import fdsPkg::*;
#(
  parameter int CLK_HZ     = 2_000_000,
  parameter int NUM_FRAMES = 27,
  parameter int FRAME_W    = 4,
  parameter int FRAME_H    = 2,
  localparam int FRM_W  = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int CNT_W  = $clog2(NUM_FRAMES + 1),
  localparam int ADDR_W = $clog2(NUM_FRAMES * FRAME_W * FRAME_H)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              go,
  input  logic [FRM_W-1:0]  startFrame,
  input  logic [CNT_W-1:0]  frameCount,
  input  logic [2:0]        rateSel,
  input  logic              cts,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  input  logic [15:0]       memRdData,
  output logic              txd,
  output logic              rts,
  output logic              busy,
  output logic              donePulse
);

  fdsStrobes_t stb;
  logic txIdle, byteDone, lastWord;

  fdsControl #(.NUM_FRAMES(NUM_FRAMES)) uCtrl (
    .clk(clk), .rstN(rstN), .go(go), .frameCount(frameCount), .cts(cts),
    .txIdle(txIdle), .byteDone(byteDone), .lastWord(lastWord),
    .stb(stb), .busy(busy), .donePulse(donePulse)
  );

  fdsDatapath #(
    .CLK_HZ(CLK_HZ), .NUM_FRAMES(NUM_FRAMES), .FRAME_W(FRAME_W), .FRAME_H(FRAME_H)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .startFrame(startFrame), .rateSel(rateSel),
    .memRdData(memRdData), .memAddr(memAddr), .txd(txd), .txIdle(txIdle),
    .byteDone(byteDone), .lastWord(lastWord)
  );

  assign memRdEn = stb.memRd;
  assign rts     = busy;

endmodule

// File: rtl/fdsChecker.sv
module fdsChecker (
  input logic clk,
  input logic rstN,
  input logic go,
  input logic busy,
  input logic rts,
  input logic donePulse,
  input logic txd,
  input logic memRdEn
);

  AST_IDLE_LINE_MARK:  assert property (@(posedge clk) disable iff (!rstN) !busy |-> txd);                      // R8
  AST_RUN_FROM_GO:     assert property (@(posedge clk) disable iff (!rstN) $rose(busy) |-> $past(go));          // R8
  AST_DONE_ONE_CYCLE:  assert property (@(posedge clk) disable iff (!rstN) donePulse |=> !donePulse);           // R9
  AST_DONE_CLOSES_RUN: assert property (@(posedge clk) disable iff (!rstN) donePulse |=> !busy);                // R9
  AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rstN) donePulse |-> txd && $past(txd));    // R9
  AST_READS_IN_RUN:    assert property (@(posedge clk) disable iff (!rstN) memRdEn |-> busy && rts);            // R5

endmodule

bind frameDumpStreamer fdsChecker uChk (
  .clk(clk), .rstN(rstN), .go(go), .busy(busy), .rts(rts),
  .donePulse(donePulse), .txd(txd), .memRdEn(memRdEn)
);

// File: tb/tb_frameDumpStreamer.sv
module tb_frameDumpStreamer;

  localparam int CLK_HZ = 2_000_000;
  localparam int NF     = 27;
  localparam int FW     = 4;
  localparam int FH     = 2;
  localparam int WORDS  = FW * FH;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        go = 1'b0;
  logic [4:0]  startFrame = '0;
  logic [4:0]  frameCount = '0;
  logic [2:0]  rateSel = '0;
  logic        cts = 1'b1;
  logic [7:0]  memAddr;
  logic        memRdEn;
  logic [15:0] memRdData = '0;
  logic        txd, rts, busy, donePulse;

  always #2.5 clk = ~clk;

  frameDumpStreamer dut (
    .clk(clk), .rstN(rstN), .go(go), .startFrame(startFrame), .frameCount(frameCount),
    .rateSel(rateSel), .cts(cts), .memAddr(memAddr), .memRdEn(memRdEn),
    .memRdData(memRdData), .txd(txd), .rts(rts), .busy(busy), .donePulse(donePulse)
  );

  int checks = 0, errors = 0;
  int cyc = 0, readCount = 0, doneCount = 0, doneCycle = 0, lastStartCycle = 0;
  int curDiv = 8;
  bit finished = 0;
  byte unsigned rxQ[$];
  byte unsigned expQ[$];

  function automatic logic [15:0] memWord(int a);
    return 16'((a * 40503 + 4660) ^ (a << 7));
  endfunction

  function automatic int expDiv(int sel);
    int rates[8] = '{1200, 2400, 9600, 28800, 38400, 57600, 115200, 230400};
    return CLK_HZ / rates[sel];
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic buildExp(int start, int count);
    int f = start;
    expQ.delete();
    for (int k = 0; k < count; k++) begin
      expQ.push_back(8'hA5); expQ.push_back(8'(f));
      expQ.push_back(8'(FW >> 8)); expQ.push_back(8'(FW));
      expQ.push_back(8'(FH >> 8)); expQ.push_back(8'(FH));
      expQ.push_back(8'h00); expQ.push_back(8'h00);
      for (int w = 0; w < WORDS; w++) begin
        logic [15:0] d = memWord(f * WORDS + w);
        expQ.push_back(d[15:8]); expQ.push_back(d[7:0]);
      end
      f = (f + 1) % NF;
    end
  endtask

  // memory model, one cycle of latency
  always @(posedge clk) if (memRdEn) memRdData <= memWord(int'(memAddr));
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (memRdEn) readCount++;
    if (donePulse) begin doneCount++; doneCycle = cyc; end
  end

  // serial decoder; also checks the cts rule at every start bit
  initial begin
    logic lastCts = 1'b1, prevCts;
    forever begin
      @(negedge clk);
      prevCts = lastCts;
      lastCts = cts;
      if (rstN && txd === 1'b0) begin
        logic [7:0] by;
        check(prevCts == 1'b1, "R7 start without cts", prevCts, 1);
        lastStartCycle = cyc;
        repeat (curDiv / 2) @(negedge clk);
        check(txd == 1'b0, "R2 start bit", txd, 0);
        for (int b = 0; b < 8; b++) begin
          repeat (curDiv) @(negedge clk);
          by[b] = txd;
        end
        repeat (curDiv) @(negedge clk);
        check(txd == 1'b1, "R2 stop bit", txd, 1);
        rxQ.push_back(by);
        lastCts = cts;
      end
    end
  end

  // mode: 0 cts high, 1 random toggling, 2 long stall; disturb: go+rate change mid-run
  task automatic runDump(int start, int count, int sel, int mode, bit disturb);
    int n = 0;
    startFrame = 5'(start); frameCount = 5'(count); rateSel = 3'(sel);
    buildExp(start, count);
    curDiv = expDiv(sel);
    rxQ.delete(); readCount = 0; doneCount = 0;
    @(posedge clk); #1 go = 1'b1;
    @(posedge clk); #1 go = 1'b0;
    @(negedge clk);
    if (count > 0) check(busy && rts, "R8 busy/rts in run", {busy, rts}, 3);
    while (doneCount == 0 && n < 60000) begin
      @(posedge clk); #1;
      n++;
      if (mode == 1) cts = ($urandom % 3) != 0;
      else if (mode == 2) cts = !(n >= 300 && n < 1500);
      else cts = 1'b1;
      if (disturb && n == 400) begin go = 1'b1; startFrame = 5'd0; frameCount = 5'd1; rateSel = 3'd0; end
      if (disturb && n == 401) go = 1'b0;
      @(negedge clk);
    end
    cts = 1'b1;
    repeat (2) @(negedge clk);
    check(doneCount == 1, "R9 one done pulse", doneCount, 1);
    check(!busy && !rts, "R9 busy low after done", {busy, rts}, 0);
    check(readCount == count * WORDS, "R5 read count", readCount, count * WORDS);
    check(rxQ.size() == expQ.size(), "R6 byte count", rxQ.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < rxQ.size(); i++)
      check(rxQ[i] == expQ[i], (i % 24 < 8) ? "R4 header byte" : "R5 pixel byte", rxQ[i], expQ[i]);
    if (count > 0)
      check(doneCycle - lastStartCycle == 10 * curDiv + 1, "R9 done timing",
            doneCycle - lastStartCycle, 10 * curDiv + 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(txd && !rts && !busy && !donePulse && !memRdEn, "R1 reset state",
          {txd, rts, busy, donePulse, memRdEn}, 5'b10000);
    #1 rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(txd == 1'b1, "R1 idle line", txd, 1);

    runDump(3, 2, 7, 0, 0);          // R2 R4 R5 R6 basic
    runDump(NF - 1, 3, 6, 1, 1);     // R6 wrap, R7 random cts, R3 R10 disturb
    runDump(10, 1, 5, 2, 0);         // R7 long stall, R3 slower rate
    runDump(5, 0, 7, 0, 0);          // R11 zero frames
    check(rxQ.size() == 0 && readCount == 0, "R11 nothing sent", rxQ.size() + readCount, 0);
    for (int r = 0; r < 3; r++)
      runDump($urandom % NF, 1 + $urandom % 2, 6 + $urandom % 2, 1, 0);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule